// File: doc/BRIEF.md
# Receive Byte Buffer with Hysteretic Flow Control

This block sits between a serial receiver and the logic that consumes received bytes. Each clean byte from the receiver is stored in a circular buffer. The consumer takes bytes out in arrival order by pulsing a read request. Each answer comes back one cycle after its request.

Hardware flow control runs on its own, driven by two occupancy marks. A clean arrival that finds the buffer at or above the high mark drives the active-low request-to-send output to its pause level. The pause is lifted only when a read leaves the occupancy under the low mark. This gap keeps the line from toggling while the buffer is near full.

Bytes that carry a line error, or that find no room, are dropped and recorded in a sticky status byte. While an error is recorded, read requests return that status byte in place of data and remove nothing. Two modem inputs are also tracked:
- The clear-to-send input holds off local transmission through a pause flag.
- A drop of the data-set-ready input reports a disconnected peer.

A mode input switches all handshaking off.

Top module: `rx_flow_buffer`

## Requirements
- R1: Clean bytes are returned in arrival order, and the pointers wrap after 4096 entries. A read of a non-empty buffer with no error recorded raises `rd_valid` with the oldest byte on `rd_data` one cycle after the request. At most one of `rd_valid`, `rd_err` and `rd_none` is high in any cycle.
- R2: With `hs_en` high, a clean byte that arrives while the occupancy is at least 3840 (capacity minus 256) drives `rts_n` high from the next cycle.
- R3: A paused `rts_n` returns low in the cycle after a read that leaves the occupancy below 1024. No other event releases it.
- R4: A clean byte that arrives while 4096 bytes are held is discarded. It sets status bit 7 (receive error) and bit 6 (buffer overrun).
- R5: A byte whose `rx_err` is nonzero is discarded. The status gains bit 7 together with `rx_err` in bits 3..0 (bit 0 line overrun, bit 1 parity, bit 2 framing, bit 3 break).
- R6: A read request while status bit 7 is set raises `rd_err` one cycle later, with the status byte from the request cycle on `rd_data`. It removes no byte.
- R7: A read request on an empty buffer with no error recorded raises `rd_none` one cycle later. `empty` is high whenever no byte is held.
- R8: With `hs_en` high, a change of `cts_n` is copied into `tx_pause` on the next cycle (1 = transmission halted).
- R9: With `hs_en` high, a low-to-high change of `dsr_n` sets status bits 7 and 5.
- R10: With `hs_en` low, `rts_n` stays low, `tx_pause` keeps its value, and `dsr_n` changes leave the status untouched.
- R11: Status bits are sticky and clear only on `stat_clr`. An event in the same cycle as `stat_clr` still sets its bits.
- R12: A clean arrival and a successful read in the same cycle leave the occupancy unchanged.
- R13: After reset the buffer is empty, `rts_n`, `tx_pause`, the status and all read answers are low, and both modem inputs count as having been low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_en | input | 1 | Enables flow control and modem tracking |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Line error flags of the byte: overrun, parity, framing, break |
| rd_req | input | 1 | Consumer read request |
| stat_clr | input | 1 | Clears the sticky status |
| cts_n | input | 1 | Clear-to-send level, low = active |
| dsr_n | input | 1 | Data-set-ready level, low = active |
| rd_valid | output | 1 | Data answer to the previous request |
| rd_err | output | 1 | Error answer: `rd_data` holds the status |
| rd_none | output | 1 | Empty answer to the previous request |
| rd_data | output | 8 | Byte or status code of the answer |
| empty | output | 1 | No byte held |
| stat | output | 8 | Sticky status byte |
| rts_n | output | 1 | Request-to-send, high = pause the remote sender |
| tx_pause | output | 1 | Local transmission must halt |

## Verification
The properties take `hs_en` to be steady between resets. They also take the modem levels and the receive strobe to be synchronous to `clk`, since synchronising the pins is left outside this block.

The stimulus follows both rules. It changes `hs_en` only while reset is held, and it drives every input on the falling clock edge.

From there it covers the ordinary traffic and the corner cases:
- ordinary reads and writes;
- filling past the high mark and up to full;
- overflow;
- draining under the low mark;
- pointer wrap;
- a write and a read in the same cycle;
- error reads, and a status clear that lands in the same cycle as a new event.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

  localparam int unsigned ST_RXERR = 7;
  localparam int unsigned ST_OVFL  = 6;
  localparam int unsigned ST_DISC  = 5;

  function automatic logic [7:0] line_err_code(input logic [3:0] flags);
    return {4'b1000, flags};
  endfunction

  function automatic logic [7:0] full_code();
    logic [7:0] c;
    c = '0;
    c[ST_RXERR] = 1'b1;
    c[ST_OVFL]  = 1'b1;
    return c;
  endfunction

  function automatic logic [7:0] disc_code();
    logic [7:0] c;
    c = '0;
    c[ST_RXERR] = 1'b1;
    c[ST_DISC]  = 1'b1;
    return c;
  endfunction

  function automatic int unsigned pause_mark(input int unsigned depth, input int unsigned guard);
    return depth - guard;
  endfunction

endpackage

// File: rtl/rxfb_store.sv
module rxfb_store #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] occ
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;

  // pointers wrap naturally: DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (push) mem[head] <= din;
    if (pop)  dout <= mem[tail];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) head <= head + 1'b1;
      if (pop)  tail <= tail + 1'b1;
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

endmodule

// File: rtl/rxfb_flow.sv
module rxfb_flow #(
  parameter int unsigned CW = 13,
  parameter int unsigned HI = 3840,
  parameter int unsigned LO = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_en,
  input  logic          arrive,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] occ,
  output logic          pause
);

  localparam logic [CW-1:0] HI_C = CW'(HI);
  localparam logic [CW-1:0] LO_C = CW'(LO);

  logic [CW-1:0] occ_after;
  logic          ev_set, ev_release;

  assign occ_after  = occ + CW'(push) - CW'(pop);
  assign ev_set     = hs_en && arrive && (occ >= HI_C);
  assign ev_release = pop && (occ_after < LO_C);

  always_ff @(posedge clk) begin
    if (!rst_n)          pause <= 1'b0;
    else if (ev_set)     pause <= 1'b1;
    else if (ev_release) pause <= 1'b0;
  end

endmodule

// File: rtl/rxfb_modem.sv
module rxfb_modem (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_en,
  input  logic cts_n,
  input  logic dsr_n,
  output logic tx_pause,
  output logic dsr_drop
);

  logic cts_prev, dsr_prev;

  assign dsr_drop = hs_en && dsr_n && !dsr_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_prev <= 1'b0;
      dsr_prev <= 1'b0;
      tx_pause <= 1'b0;
    end else begin
      cts_prev <= cts_n;
      dsr_prev <= dsr_n;
      if (hs_en && (cts_n != cts_prev)) tx_pause <= cts_n;
    end
  end

endmodule

// File: rtl/rx_flow_buffer.sv
module rx_flow_buffer #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned GUARD = 256,
  parameter int unsigned FREE  = 1024,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [3:0]    rx_err,
  input  logic          rd_req,
  input  logic          stat_clr,
  input  logic          cts_n,
  input  logic          dsr_n,
  output logic          rd_valid,
  output logic          rd_err,
  output logic          rd_none,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [7:0]    stat,
  output logic          rts_n,
  output logic          tx_pause
);
  import rxfb_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam int unsigned HI = pause_mark(DEPTH, GUARD);

  logic [CW-1:0] occ;
  logic [DW-1:0] mem_q;
  logic [7:0]    code_q;
  logic [7:0]    st_set;
  logic clean, full, err_held;
  logic ev_push, ev_pop, ev_drop_full, ev_drop_err, ev_rd_err, ev_rd_none;
  logic dsr_drop, pause;

  assign clean        = rx_valid && (rx_err == 4'd0);
  assign full         = (occ == DEPTH_C);
  assign err_held     = stat[ST_RXERR];
  assign empty        = (occ == '0);
  assign ev_push      = clean && !full;
  assign ev_drop_full = clean && full;
  assign ev_drop_err  = rx_valid && (rx_err != 4'd0);
  assign ev_pop       = rd_req && !err_held && !empty;
  assign ev_rd_err    = rd_req && err_held;
  assign ev_rd_none   = rd_req && !err_held && empty;

  rxfb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .din(rx_data),
    .pop(ev_pop), .dout(mem_q), .occ(occ)
  );

  rxfb_flow #(.CW(CW), .HI(HI), .LO(FREE)) u_flow (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .arrive(clean),
    .push(ev_push), .pop(ev_pop), .occ(occ), .pause(pause)
  );

  rxfb_modem u_modem (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .cts_n(cts_n),
    .dsr_n(dsr_n), .tx_pause(tx_pause), .dsr_drop(dsr_drop)
  );

  assign rts_n = pause;

  always_comb begin
    st_set = '0;
    if (ev_drop_err)  st_set = st_set | line_err_code(rx_err);
    if (ev_drop_full) st_set = st_set | full_code();
    if (dsr_drop)     st_set = st_set | disc_code();
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_none  <= 1'b0;
      code_q   <= '0;
    end else begin
      stat     <= (stat_clr ? 8'h00 : stat) | st_set;
      rd_valid <= ev_pop;
      rd_err   <= ev_rd_err;
      rd_none  <= ev_rd_none;
      if (ev_rd_err) code_q <= stat;
    end
  end

  assign rd_data = rd_err ? DW'(code_q) : mem_q;

endmodule

// File: rtl/rx_flow_buffer_chk.sv
module rx_flow_buffer_chk #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned FREE  = 1024,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [3:0]    rx_err,
  input logic          rd_req,
  input logic          stat_clr,
  input logic          hs_en,
  input logic          rts_n,
  input logic          tx_pause,
  input logic [7:0]    stat,
  input logic          rd_valid,
  input logic          rd_err,
  input logic          rd_none,
  input logic [CW-1:0] occ
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] FREE_C  = CW'(FREE);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_C);

  p_one_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, rd_err, rd_none}));

  p_pause_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> $past(hs_en) && $past(rx_valid) && ($past(rx_err) == 4'd0));

  p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> $past(rd_req) && (occ < FREE_C));

  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (rx_err == 4'd0) && (occ == DEPTH_C) |=> stat[7] && stat[6] && (occ <= $past(occ)));

  p_err_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (rx_err != 4'd0) |=> stat[7] && (occ <= $past(occ)));

  p_err_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && stat[7] |=> rd_err && !rd_valid);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !stat[7] && (occ == '0) |=> rd_none);

  p_hs_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |=> $stable(tx_pause));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stat[7] && !stat_clr |=> stat[7]);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && (rx_err == 4'd0) && rd_req && !stat[7] && (occ != '0) && (occ != DEPTH_C)
      |=> occ == $past(occ));

endmodule

bind rx_flow_buffer rx_flow_buffer_chk #(.DEPTH(DEPTH), .FREE(FREE)) u_chk (.*);

// File: tb/rx_flow_buffer_tb.sv
`timescale 1ns/1ps
module rx_flow_buffer_tb;
  localparam int DEPTH = 4096;
  localparam int GUARD = 256;
  localparam int FREE  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_en = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [3:0] rx_err = '0;
  logic rd_req = 1'b0;
  logic stat_clr = 1'b0;
  logic cts_n = 1'b0;
  logic dsr_n = 1'b0;
  logic rd_valid, rd_err, rd_none, empty, rts_n, tx_pause;
  logic [7:0] rd_data, stat;

  always #4 clk = ~clk;

  rx_flow_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err), .rd_req(rd_req), .stat_clr(stat_clr),
    .cts_n(cts_n), .dsr_n(dsr_n), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_none(rd_none), .rd_data(rd_data), .empty(empty), .stat(stat),
    .rts_n(rts_n), .tx_pause(tx_pause)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int wd = 0;
  bit done = 1'b0;
  string req = "R13";

  logic [7:0] mq[$];
  logic [7:0] m_stat, e_data;
  bit m_pause, m_tx, m_pcts, m_pdsr, e_val, e_err, e_none;

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mq.delete();
    m_stat = '0; m_pause = 0; m_tx = 0; m_pcts = 0; m_pdsr = 0;
    e_val = 0; e_err = 0; e_none = 0; e_data = '0;
  endtask

  task automatic model_update();
    int occ;
    logic [7:0] nb;
    bit popped;
    occ = mq.size(); nb = '0; popped = 0;
    e_val = 0; e_err = 0; e_none = 0;
    if (rd_req) begin
      if (m_stat[7]) begin e_err = 1; e_data = m_stat; end
      else if (occ == 0) e_none = 1;
      else begin e_val = 1; e_data = mq.pop_front(); popped = 1; end
    end
    if (rx_valid) begin
      if (rx_err != 0) nb = nb | 8'h80 | {4'h0, rx_err};
      else begin
        if (hs_en && occ >= DEPTH - GUARD) m_pause = 1;
        if (occ == DEPTH) nb = nb | 8'hC0;
        else mq.push_back(rx_data);
      end
    end
    if (popped && mq.size() < FREE) m_pause = 0;
    if (hs_en && (cts_n != m_pcts)) m_tx = cts_n;
    if (hs_en && dsr_n && !m_pdsr) nb = nb | 8'hA0;
    m_pcts = cts_n; m_pdsr = dsr_n;
    m_stat = (stat_clr ? 8'h00 : m_stat) | nb;
  endtask

  task automatic compare();
    chk("empty", 16'(empty), 16'(mq.size() == 0));
    chk("rts_n", 16'(rts_n), 16'(m_pause));
    chk("tx_pause", 16'(tx_pause), 16'(m_tx));
    chk("stat", 16'(stat), 16'(m_stat));
    chk("rd_valid", 16'(rd_valid), 16'(e_val));
    chk("rd_err", 16'(rd_err), 16'(e_err));
    chk("rd_none", 16'(rd_none), 16'(e_none));
    if (e_val || e_err) chk("rd_data", 16'(rd_data), 16'(e_data));
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input logic [3:0] e,
                     input bit rd, input bit clr);
    rx_valid = v; rx_data = d; rx_err = e; rd_req = rd; stat_clr = clr;
    step();
    rx_valid = 0; rd_req = 0; stat_clr = 0; rx_err = '0;
  endtask

  task automatic do_reset(input bit hs);
    @(negedge clk);
    rst_n = 0; hs_en = hs; cts_n = 0; dsr_n = 0;
    rx_valid = 0; rd_req = 0; stat_clr = 0; rx_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    req = "R13";
    compare();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);

    // R1 / R7: ordered return, empty reads
    req = "R7";
    cyc(0, 8'h00, 4'h0, 1, 0);
    req = "R1";
    for (int i = 0; i < 5; i++) cyc(1, 8'(8'h30 + i), 4'h0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 8'h00, 4'h0, 1, 0);
    req = "R7";
    cyc(0, 8'h00, 4'h0, 1, 0);

    // R12: simultaneous write and read
    req = "R12";
    cyc(1, 8'h5A, 4'h0, 0, 0);
    cyc(1, 8'hA5, 4'h0, 1, 0);
    cyc(1, 8'h3C, 4'h0, 1, 0);
    cyc(0, 8'h00, 4'h0, 1, 0);
    cyc(0, 8'h00, 4'h0, 1, 0);

    // R5 / R6 / R11: line errors, error reads, clearing
    for (int b = 0; b < 4; b++) begin
      req = "R5";
      cyc(1, 8'hEE, 4'(1 << b), 0, 0);
      cyc(1, 8'h11, 4'h0, 0, 0);
      req = "R6";
      cyc(0, 8'h00, 4'h0, 1, 0);
      req = "R11";
      cyc(0, 8'h00, 4'h0, 0, 1);
      cyc(0, 8'h00, 4'h0, 1, 0);
    end
    req = "R11";
    cyc(1, 8'h00, 4'hC, 0, 1);
    cyc(0, 8'h00, 4'h0, 0, 0);
    cyc(0, 8'h00, 4'h0, 0, 1);

    // R8 / R9: modem lines with handshake on
    req = "R8";
    cts_n = 1; step(); step();
    cts_n = 0; step();
    req = "R9";
    dsr_n = 1; step(); step();
    dsr_n = 0; step();
    req = "R11";
    cyc(0, 8'h00, 4'h0, 0, 1);

    // R2 / R4: fill past the high mark and to overflow
    while (mq.size() > 0) cyc(0, 8'h00, 4'h0, 1, 0);
    for (int i = 0; i < DEPTH + 3; i++) begin
      req = (i < DEPTH) ? "R2" : "R4";
      cyc(1, 8'(i * 7 + 1), 4'h0, 0, 0);
    end
    req = "R6";
    cyc(0, 8'h00, 4'h0, 1, 0);
    req = "R11";
    cyc(0, 8'h00, 4'h0, 0, 1);

    // R3: drain under the low mark; wrap for R1
    req = "R3";
    while (mq.size() > FREE - 2) cyc(0, 8'h00, 4'h0, 1, 0);
    req = "R1";
    while (mq.size() > 0) cyc(0, 8'h00, 4'h0, 1, 0);
    for (int i = 0; i < 20; i++) cyc(1, 8'(i + 8'h80), 4'h0, 0, 0);
    for (int i = 0; i < 21; i++) cyc(0, 8'h00, 4'h0, 1, 0);

    // R10: handshake off
    do_reset(1'b0);
    req = "R10";
    cts_n = 1; step(); step();
    dsr_n = 1; step(); step();
    cts_n = 0; dsr_n = 0; step();
    for (int i = 0; i < DEPTH - GUARD + 20; i++) cyc(1, 8'(i), 4'h0, 0, 0);
    cyc(0, 8'h00, 4'h0, 1, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule